// File: doc/BRIEF.md
# Glitch-free limp-mode clock divider

This block generates the clock-enable set a chip runs from when its PLL is bypassed and the reference input clock has to carry the whole device at low speed. The reference clock is divided by two raised to a programmable 5-bit exponent. The result is issued as a one-cycle core enable. A bus enable and an external bus enable are derived from it at fixed ratios. All outputs are enable pulses in the reference clock domain, so downstream logic stays on one clock and no derived clock edge can be cut short.

The operating mode is loaded from configuration inputs while reset is held and kept afterwards. Limp operation is requested either by that reset-time mode or by a software control bit. A wake-up event withdraws the request. A requested change of mode takes effect only on a bus-enable boundary. A new exponent takes effect only when the current divided period ends. Outside limp mode the divider is bypassed: the core enable is asserted on every reference cycle, standing in for the PLL-driven rate. The external bus then runs at half the bus rate instead of at the bus rate.

Top module: `limp_clk_div`

## Requirements
- R1: In limp mode with an applied exponent n, `core_en_o` is high for exactly one reference cycle in every 2^n cycles, and the first cycle after a core pulse starts a new period.
- R2: With exponent 0 applied in limp mode, `core_en_o` is high on every reference cycle.
- R3: `div_exp_i` is sampled only in a cycle where `core_en_o` is high. The value sampled there sets the length of the period that follows. A change at any other time leaves the period in progress at its old length.
- R4: `bus_en_o` is high on every second `core_en_o` pulse and never without one. After reset the first bus pulse coincides with the second core pulse.
- R5: `xbus_en_o` coincides with every `bus_en_o` pulse in limp mode. In normal mode it coincides with every second bus pulse. After a change of mode, or after reset, the first normal-mode external pulse is the second bus pulse.
- R6: In normal mode (`limp_o` low), `core_en_o` is high on every reference cycle, whatever the value of `div_exp_i`.
- R7: `mode_o` takes the value of `cfg_mode_i` while `rst_ni` is low and then holds it until the next reset. The encoding is 0 crystal reference, 1 external reference, 2 limp, 3 reserved (treated as normal). The limp request and `limp_o` both start high exactly when the loaded mode is 2.
- R8: `sw_limp_i` high at a clock edge sets the limp request. The mode changes at the clock edge of the next cycle in which `bus_en_o` is high.
- R9: `wake_i` high at a clock edge clears the limp request and has priority over `sw_limp_i`. The return to normal mode happens at the clock edge of the next cycle in which `bus_en_o` is high.
- R10: `limp_o` reports the mode that currently sets the enable timing, and it changes only at the edge that ends a cycle in which `bus_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference input clock |
| rst_ni | input | 1 | Active-low reset; mode configuration is loaded while low |
| cfg_mode_i | input | 2 | Reset-time mode: 0 crystal, 1 external reference, 2 limp, 3 reserved |
| sw_limp_i | input | 1 | Software limp request |
| wake_i | input | 1 | Wake-up event, clears the limp request |
| div_exp_i | input | DIV_W | Divider exponent n (divide by 2^n) |
| core_en_o | output | 1 | Core clock enable pulse |
| bus_en_o | output | 1 | Internal bus clock enable pulse |
| xbus_en_o | output | 1 | External bus clock enable pulse |
| limp_o | output | 1 | Limp mode active |
| mode_o | output | 2 | Mode captured at reset |

## Verification
The bench builds the block with its default 5-bit exponent, so the counter is the full 31 bits wide. Stimulus keeps exponents between 0 and 6, so every period, every exponent change at a terminal count, and both directions of the mode switch occur many times within the cycle budget. Reset is applied with the limp code and with the external-reference code, so both start-up paths are covered. Random software requests and wake events arrive at arbitrary phases of the bus and external-bus cycles. This places switch requests both just before and just after bus boundaries.

// File: rtl/limp_clk_pkg.sv
package limp_clk_pkg;
  typedef enum logic [1:0] {
    MODE_XTAL   = 2'd0,
    MODE_EXTREF = 2'd1,
    MODE_LIMP   = 2'd2,
    MODE_RSVD   = 2'd3
  } clk_mode_e;
endpackage

// File: rtl/limp_mode_ctl.sv
module limp_mode_ctl
  import limp_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_mode_i,
  input  logic       sw_limp_i,
  input  logic       wake_i,
  input  logic       bus_edge_i,
  output logic [1:0] mode_o,
  output logic       limp_o,
  output logic       switch_o
);
  clk_mode_e mode_q;
  logic      want_q, limp_q, want_d;

  always_comb begin
    want_d = want_q;
    if (sw_limp_i) want_d = 1'b1;
    if (wake_i)    want_d = 1'b0;
  end

  // configuration is loaded while reset is held, so reset acts synchronously here
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= clk_mode_e'(cfg_mode_i);
      want_q <= (cfg_mode_i == MODE_LIMP);
      limp_q <= (cfg_mode_i == MODE_LIMP);
    end else begin
      want_q <= want_d;
      if (bus_edge_i) limp_q <= want_q;
    end
  end

  assign mode_o   = mode_q;
  assign limp_o   = limp_q;
  assign switch_o = bus_edge_i && (want_q != limp_q);

  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(mode_q));
  assert_switch_on_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_edge_i |=> $stable(limp_q));
  assert_wake_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !want_q);
endmodule

// File: rtl/limp_pow2_div.sv
module limp_pow2_div #(
  parameter int DIV_W = 5,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             limp_i,
  input  logic [DIV_W-1:0] div_exp_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, term;
  logic [DIV_W-1:0] shadow_q;

  // bypassed in normal mode: terminal count of zero
  assign term   = limp_i ? ((CNT_W'(1) << shadow_q) - CNT_W'(1)) : '0;
  assign tick_o = (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (tick_o) begin
      cnt_q    <= '0;
      shadow_q <= div_exp_i;
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assert_shadow_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(shadow_q));
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term);
  assert_normal_every_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !limp_i |-> tick_o);
endmodule

// File: rtl/limp_ratio_gen.sv
module limp_ratio_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic limp_i,
  input  logic switch_i,
  output logic bus_en_o,
  output logic xbus_en_o
);
  logic bus_ph_q, xbus_ph_q;

  assign bus_en_o  = tick_i && bus_ph_q;
  assign xbus_en_o = bus_en_o && (limp_i || xbus_ph_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ph_q  <= 1'b0;
      xbus_ph_q <= 1'b0;
    end else begin
      if (tick_i) bus_ph_q <= !bus_ph_q;
      if (switch_i)                 xbus_ph_q <= 1'b0;
      else if (bus_en_o && !limp_i) xbus_ph_q <= !xbus_ph_q;
    end
  end

  assert_bus_needs_core_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> tick_i);
  assert_bus_alternates_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |=> !bus_en_o || !tick_i || !$stable(bus_ph_q));
  assert_xbus_needs_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xbus_en_o |-> bus_en_o);
endmodule

// File: rtl/limp_clk_div.sv
module limp_clk_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_mode_i,
  input  logic             sw_limp_i,
  input  logic             wake_i,
  input  logic [DIV_W-1:0] div_exp_i,
  output logic             core_en_o,
  output logic             bus_en_o,
  output logic             xbus_en_o,
  output logic             limp_o,
  output logic [1:0]       mode_o
);
  logic tick, bus_en, limp, mode_switch;

  limp_mode_ctl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_mode_i (cfg_mode_i),
    .sw_limp_i  (sw_limp_i),
    .wake_i     (wake_i),
    .bus_edge_i (bus_en),
    .mode_o     (mode_o),
    .limp_o     (limp),
    .switch_o   (mode_switch)
  );

  limp_pow2_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .limp_i    (limp),
    .div_exp_i (div_exp_i),
    .tick_o    (tick)
  );

  limp_ratio_gen u_ratio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .limp_i    (limp),
    .switch_i  (mode_switch),
    .bus_en_o  (bus_en),
    .xbus_en_o (xbus_en_o)
  );

  assign core_en_o = tick;
  assign bus_en_o  = bus_en;
  assign limp_o    = limp;
endmodule

// File: tb/limp_clk_div_tb.sv
module limp_clk_div_tb;
  localparam int DIV_W = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       cfg_mode_i = 2'd2;
  logic             sw_limp_i = 1'b0;
  logic             wake_i = 1'b0;
  logic [DIV_W-1:0] div_exp_i = '0;
  logic core_en_o, bus_en_o, xbus_en_o, limp_o;
  logic [1:0] mode_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // reference model state
  longint m_cnt;
  int m_sh, m_limp, m_want, m_bph, m_xph, m_mode;

  always #4 clk = ~clk;

  limp_clk_div #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_mode_i(cfg_mode_i), .sw_limp_i(sw_limp_i),
    .wake_i(wake_i), .div_exp_i(div_exp_i), .core_en_o(core_en_o), .bus_en_o(bus_en_o),
    .xbus_en_o(xbus_en_o), .limp_o(limp_o), .mode_o(mode_o)
  );

  function automatic int exp_core();
    longint term = m_limp ? ((64'd1 << m_sh) - 1) : 0;
    return (m_cnt == term) ? 1 : 0;
  endfunction
  function automatic int exp_bus();
    return exp_core() & m_bph;
  endfunction
  function automatic int exp_xbus();
    return exp_bus() & (m_limp | m_xph);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic check_all(string core_tag);
    chk(core_tag, int'(core_en_o), exp_core());
    chk("R4", int'(bus_en_o), exp_bus());
    chk("R5", int'(xbus_en_o), exp_xbus());
    chk("R10", int'(limp_o), m_limp);
    chk("R7", int'(mode_o), m_mode);
  endtask

  task automatic model_step();
    int c = exp_core();
    int b = exp_bus();
    int chg = b && (m_want != m_limp);
    int nwant = m_want;
    if (sw_limp_i) nwant = 1;
    if (wake_i)    nwant = 0;
    if (chg)                  m_xph = 0;
    else if (b && !m_limp)    m_xph = !m_xph;
    if (b) m_limp = m_want;
    m_want = nwant;
    if (c) begin m_cnt = 0; m_sh = int'(div_exp_i); m_bph = !m_bph; end
    else m_cnt++;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic do_reset(int cfg);
    @(negedge clk);
    rst_ni = 1'b0;
    cfg_mode_i = 2'(cfg);
    sw_limp_i = 1'b0;
    wake_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    cfg_mode_i = 2'(cfg ^ 3);
    m_mode = cfg; m_want = (cfg == 2); m_limp = (cfg == 2);
    m_cnt = 0; m_sh = 0; m_bph = 0; m_xph = 0;
    chk("R7", int'(mode_o), cfg);
    chk("R7", int'(limp_o), (cfg == 2) ? 1 : 0);
    chk("R4", int'(bus_en_o), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    div_exp_i = '0;
    do_reset(2);
    run(40, "R2");
    div_exp_i = 5'd3;
    run(100, "R1");
    // mid-period change: old length must finish
    while (!(exp_core() == 0 && m_cnt == 2)) cyc("R1");
    div_exp_i = 5'd1;
    run(60, "R3");
    div_exp_i = 5'd2;
    wake_i = 1'b1;
    cyc("R9");
    wake_i = 1'b0;
    run(60, "R9");
    div_exp_i = 5'd6;
    run(40, "R6");
    sw_limp_i = 1'b1;
    cyc("R8");
    sw_limp_i = 1'b0;
    run(300, "R8");
    sw_limp_i = 1'b1;
    wake_i = 1'b1;
    cyc("R9");
    sw_limp_i = 1'b0;
    wake_i = 1'b0;
    run(300, "R9");
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 40) == 0) div_exp_i = 5'($urandom_range(0, 5));
      sw_limp_i = ($urandom_range(0, 150) == 0);
      wake_i    = ($urandom_range(0, 150) == 0);
      cyc("R1");
    end
    sw_limp_i = 1'b0;
    wake_i = 1'b0;
    do_reset(1);
    run(50, "R6");
    sw_limp_i = 1'b1;
    div_exp_i = 5'd0;
    cyc("R8");
    sw_limp_i = 1'b0;
    run(50, "R2");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule